// File: doc/BRIEF.md
# Parallel Camera Frame Grabber

The grabber takes 8-bit grayscale samples from an image sensor with a parallel output. The sensor drives three timing signals alongside the data bus: a short frame pulse, a level that stays high while a row is being output, and a pixel clock. All of these are asynchronous to the system clock. The block brings them into the system clock domain and oversamples the pixel clock, which must be at least four times slower than the system clock. It rebuilds the frame and row timing from edges of these signals and counts rows and pixel slots. Only a rectangular active window is kept. Each kept sample goes into a dual-port frame buffer at an address formed from its row and column inside the window.

A host arms a capture with a one-cycle start strobe. The capture covers one whole frame. It begins at the first frame pulse after the strobe and ends at the next frame pulse. At that point a done flag is raised, or a short-frame flag if the sensor delivered too few window rows. The host then reads the buffer through a registered read port. If a start strobe arrives while a capture is already pending or running, it is refused and an overflow flag is raised. The raw scan of the sensor is about 363 slots by 317 rows, and the active window is 356 by 292. The window size and both of its offsets are parameters. The defaults are kept small, so the buffer sizes to the window the design is built with.

Top module: `cam_frame_grab`

## Requirements
- R1: After reset, frame_done_o, frame_short_o and overflow_o are all 0.
- R2: A start_i pulse in the idle state clears all three flags and arms the capture. Storage starts only at the first frame-pulse rising edge that follows. While the block is idle or armed, sensor activity leaves the buffer unchanged and leaves the flags unchanged.
- R3: A row index counts completed row-valid intervals since the frame pulse, starting at 0. A slot index counts pixel-clock rising edges since the row-valid level rose, starting at 0. A sample is stored only if the row index lies in [ROW_OFF, ROW_OFF+ACT_ROWS) and the slot index lies in [COL_OFF, COL_OFF+ACT_COLS). Every other sample is discarded.
- R4: A stored sample is the data bus value at the pixel-clock rising edge. It goes to address (row-ROW_OFF)*ACT_COLS + (slot-COL_OFF), so each frame's addressing starts again from 0.
- R5: At the frame-pulse rising edge that closes a running capture, the capture ends. frame_done_o is set if ACT_ROWS window rows were completed. The flag holds until the next accepted start.
- R6: If fewer than ACT_ROWS window rows were completed, frame_short_o is set instead of frame_done_o.
- R7: A start_i pulse while the block is armed or capturing is ignored and sets overflow_o. overflow_o holds until the next accepted start.
- R8: rd_data_o shows the buffer word at rd_addr_i one clock after the address is applied.
- R9: frame_done_o and frame_short_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_vsync_i | input | 1 | Sensor frame pulse (asynchronous) |
| cam_href_i | input | 1 | Sensor row-valid level (asynchronous) |
| cam_pclk_i | input | 1 | Sensor pixel clock (asynchronous) |
| cam_data_i | input | PIX_W | Sensor pixel data |
| start_i | input | 1 | One-cycle capture request |
| rd_addr_i | input | ADDR_W | Frame buffer read address |
| rd_data_o | output | PIX_W | Frame buffer read data, one cycle latency |
| frame_done_o | output | 1 | Full window captured |
| frame_short_o | output | 1 | Frame ended with too few window rows |
| overflow_o | output | 1 | Start request refused while busy |

## Verification
The bench builds the block with a 6-by-4 window at column offset 2 and row offset 3, and drives raw rows of 10 slots. At this size a full buffer can be read back and compared after every frame. Leading and trailing slots and rows fall outside the window on every side. A five-row frame stops two rows short, which reaches the short-frame path. The pixel clock runs at one eighth of the system clock. This keeps the edge detection at its intended oversampling margin.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_RUN   = 2'd2
  } cap_state_e;

endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= '0;
        else        chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= '0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cam_window_ctr.sv
module cam_window_ctr #(
  parameter int PIX_W    = 8,
  parameter int ACT_COLS = 32,
  parameter int ACT_ROWS = 24,
  parameter int COL_OFF  = 4,
  parameter int ROW_OFF  = 16,
  parameter int LINE_W   = 10,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              href_i,
  input  logic              href_rise_i,
  input  logic              href_fall_i,
  input  logic              pclk_rise_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PIX_W-1:0]  wr_data_o,
  output logic              rows_full_o
);

  localparam int DEPTH  = ACT_COLS * ACT_ROWS;
  localparam int ROWS_W = $clog2(ACT_ROWS + 1);
  localparam logic [LINE_W-1:0] ROW_LO = LINE_W'(ROW_OFF);
  localparam logic [LINE_W-1:0] ROW_HI = LINE_W'(ROW_OFF + ACT_ROWS);
  localparam logic [COL_W-1:0]  COL_LO = COL_W'(COL_OFF);
  localparam logic [COL_W-1:0]  COL_HI = COL_W'(COL_OFF + ACT_COLS);

  logic [LINE_W-1:0] line_q, line_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [ROWS_W-1:0] rows_q, rows_d;
  logic              in_row, in_col, hit;
  logic [ADDR_W-1:0] row_rel, col_rel, addr_d;
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [PIX_W-1:0]  wr_data_q;

  assign in_row  = (line_q >= ROW_LO) && (line_q < ROW_HI);
  assign in_col  = (col_q >= COL_LO) && (col_q < COL_HI);
  assign hit     = en_i && pclk_rise_i && href_i && in_row && in_col;
  assign row_rel = ADDR_W'(line_q - ROW_LO);
  assign col_rel = ADDR_W'(col_q - COL_LO);
  assign addr_d  = row_rel * ADDR_W'(ACT_COLS) + col_rel;

  always_comb begin
    line_d = line_q;
    col_d  = col_q;
    rows_d = rows_q;
    if (clr_i) begin
      line_d = '0;
      col_d  = '0;
      rows_d = '0;
    end else begin
      if (href_rise_i) begin
        col_d = '0;
      end else if (en_i && pclk_rise_i && href_i && (col_q != '1)) begin
        col_d = col_q + 1'b1;
      end
      if (en_i && href_fall_i) begin
        if (line_q != '1) line_d = line_q + 1'b1;
        if (in_row)       rows_d = rows_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      col_q   <= '0;
      rows_q  <= '0;
      wr_en_q <= 1'b0;
    end else begin
      line_q  <= line_d;
      col_q   <= col_d;
      rows_q  <= rows_d;
      wr_en_q <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (hit) begin
      wr_addr_q <= addr_d;
      wr_data_q <= pix_i;
    end
  end

  assign wr_en_o     = wr_en_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign rows_full_o = (rows_q == ROWS_W'(ACT_ROWS));

  AST_WADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (int'(wr_addr_o) < DEPTH)); // R4

  AST_WRITE_NEEDS_HREF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(href_i)); // R3

endmodule

// File: rtl/cam_frame_ram.sv
module cam_frame_ram #(
  parameter int PIX_W  = 8,
  parameter int DEPTH  = 768,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [PIX_W-1:0]  rd_data_o
);

  logic [PIX_W-1:0] mem_q [DEPTH];
  logic [PIX_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/cam_frame_grab.sv
module cam_frame_grab
  import cam_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int ACT_COLS    = 32,
  parameter int ACT_ROWS    = 24,
  parameter int COL_OFF     = 4,
  parameter int ROW_OFF     = 16,
  parameter int LINE_W      = 10,
  parameter int COL_W       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH      = ACT_COLS * ACT_ROWS,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cam_vsync_i,
  input  logic              cam_href_i,
  input  logic              cam_pclk_i,
  input  logic [PIX_W-1:0]  cam_data_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [PIX_W-1:0]  rd_data_o,
  output logic              frame_done_o,
  output logic              frame_short_o,
  output logic              overflow_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       sys_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign sys_rst_n = rst_pipe_q[1];

  // sensor timing and data into the system clock domain
  logic [2:0]       ctrl_lvl, ctrl_prev_q;
  logic [PIX_W-1:0] data_lvl;

  cam_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .async_i ({cam_vsync_i, cam_href_i, cam_pclk_i}),
    .sync_o  (ctrl_lvl)
  );

  cam_sync #(.W(PIX_W), .STAGES(SYNC_STAGES)) u_data_sync (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .async_i (cam_data_i),
    .sync_o  (data_lvl)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) ctrl_prev_q <= '0;
    else            ctrl_prev_q <= ctrl_lvl;
  end

  logic vs_rise, href_rise, href_fall, pclk_rise;
  assign vs_rise   =  ctrl_lvl[2] & ~ctrl_prev_q[2];
  assign href_rise =  ctrl_lvl[1] & ~ctrl_prev_q[1];
  assign href_fall = ~ctrl_lvl[1] &  ctrl_prev_q[1];
  assign pclk_rise =  ctrl_lvl[0] & ~ctrl_prev_q[0];

  // capture control
  cap_state_e state_q, state_d;
  logic       done_q, done_d, short_q, short_d, ovf_q, ovf_d;
  logic       clr, rows_full;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    short_d = short_q;
    ovf_d   = ovf_q;
    clr     = 1'b0;
    unique case (state_q)
      CAP_IDLE: begin
        if (start_i) begin
          state_d = CAP_ARMED;
          done_d  = 1'b0;
          short_d = 1'b0;
          ovf_d   = 1'b0;
        end
      end
      CAP_ARMED: begin
        if (start_i) ovf_d = 1'b1;
        if (vs_rise) begin
          state_d = CAP_RUN;
          clr     = 1'b1;
        end
      end
      CAP_RUN: begin
        if (start_i) ovf_d = 1'b1;
        if (vs_rise) begin
          state_d = CAP_IDLE;
          if (rows_full) done_d  = 1'b1;
          else           short_d = 1'b1;
        end
      end
      default: state_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      state_q <= CAP_IDLE;
      done_q  <= 1'b0;
      short_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      short_q <= short_d;
      ovf_q   <= ovf_d;
    end
  end

  // window selection and buffer
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [PIX_W-1:0]  wr_data;

  cam_window_ctr #(
    .PIX_W    (PIX_W),
    .ACT_COLS (ACT_COLS),
    .ACT_ROWS (ACT_ROWS),
    .COL_OFF  (COL_OFF),
    .ROW_OFF  (ROW_OFF),
    .LINE_W   (LINE_W),
    .COL_W    (COL_W),
    .ADDR_W   (ADDR_W)
  ) u_window (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .clr_i       (clr),
    .en_i        (state_q == CAP_RUN),
    .href_i      (ctrl_lvl[1]),
    .href_rise_i (href_rise),
    .href_fall_i (href_fall),
    .pclk_rise_i (pclk_rise),
    .pix_i       (data_lvl),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rows_full_o (rows_full)
  );

  cam_frame_ram #(.PIX_W(PIX_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign frame_done_o  = done_q;
  assign frame_short_o = short_q;
  assign overflow_o    = ovf_q;

  AST_WRITE_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wr_en |-> ($past(state_q) == CAP_RUN)); // R2

  AST_DONE_AT_VSYNC: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(frame_done_o) |-> $past(vs_rise)); // R5

  AST_SHORT_AT_VSYNC: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(frame_short_o) |-> ($past(vs_rise) && !$past(rows_full))); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (overflow_o && !start_i) |=> overflow_o); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(frame_done_o && frame_short_o)); // R9

endmodule

// File: tb/sim_cam_frame_grab.sv
module sim_cam_frame_grab;

  localparam int COLS    = 6;
  localparam int ROWS    = 4;
  localparam int C_OFF   = 2;
  localparam int R_OFF   = 3;
  localparam int RAW_PIX = 10;
  localparam int DEPTH   = COLS * ROWS;
  localparam int AW      = $clog2(DEPTH);

  logic          clk, rst_n, pclk, vsync, href, start;
  logic [7:0]    data;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          done, short_f, ovf;

  cam_frame_grab #(
    .ACT_COLS (COLS), .ACT_ROWS (ROWS), .COL_OFF (C_OFF), .ROW_OFF (R_OFF)
  ) u0 (
    .clk (clk), .rst_n (rst_n),
    .cam_vsync_i (vsync), .cam_href_i (href), .cam_pclk_i (pclk),
    .cam_data_i (data), .start_i (start), .rd_addr_i (rd_addr),
    .rd_data_o (rd_data), .frame_done_o (done),
    .frame_short_o (short_f), .overflow_o (ovf)
  );

  always #4  clk  = ~clk;   // 125 MHz
  always #32 pclk = ~pclk;  // pixel clock, 8 system cycles

  typedef struct { int addr; logic [7:0] d; } item_t;
  item_t      sb_q[$];
  logic [7:0] shadow [DEPTH];
  bit         seen [DEPTH];
  int         checks = 0, errors = 0;
  bit         finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_val(int seed, int l, int p);
    return 8'(seed * 29 + l * 13 + p * 7 + 1);
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // driver: raw rows; pushes expected window samples when storing is expected
  task automatic send_rows(int nrows, int seed, bit store);
    for (int l = 0; l < nrows; l++) begin
      @(negedge pclk);
      href = 1'b1;
      for (int p = 0; p < RAW_PIX; p++) begin
        data = pix_val(seed, l, p);
        if (store && l >= R_OFF && l < R_OFF + ROWS && p >= C_OFF && p < C_OFF + COLS)
          sb_q.push_back('{addr: (l - R_OFF) * COLS + (p - C_OFF), d: data});
        @(negedge pclk);
      end
      href = 1'b0;
      data = 8'h00;
      repeat (3) @(negedge pclk);
    end
  endtask

  task automatic vsync_pulse();
    @(negedge pclk) vsync = 1'b1;
    @(negedge pclk) vsync = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(int nrows, int seed, bit store);
    vsync_pulse();
    send_rows(nrows, seed, store);
    vsync_pulse();
  endtask

  // monitor: applies the queued results, then reads the whole buffer back
  task automatic check_buffer(string tag);
    while (sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      shadow[it.addr] = it.d;
      seen[it.addr]   = 1'b1;
    end
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk) rd_addr = AW'(a);
      @(negedge clk);
      if (seen[a]) chk($sformatf("%s R3 R4 R8 addr %0d", tag, a), 32'(rd_data), 32'(shadow[a]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clk = 0; pclk = 0; rst_n = 0; vsync = 0; href = 0; start = 0;
    data = 0; rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk("R1 done after reset",     32'(done),    0);
    chk("R1 short after reset",    32'(short_f), 0);
    chk("R1 overflow after reset", 32'(ovf),     0);

    // full frame of 9 raw rows: rows 3..6 are window rows
    pulse_start();
    send_frame(9, 1, 1'b1);
    chk("R5 done after full frame", 32'(done),    1);
    chk("R6 R9 no short on full",   32'(short_f), 0);
    check_buffer("frame1");

    // no start: a frame must not touch the buffer or the flags
    send_frame(9, 2, 1'b0);
    chk("R2 done unchanged while idle",  32'(done),    1);
    chk("R2 short unchanged while idle", 32'(short_f), 0);
    check_buffer("idle frame R2");

    // accepted start clears flags; rows before the frame pulse are ignored
    pulse_start();
    chk("R2 start clears done", 32'(done), 0);
    send_rows(2, 7, 1'b0);
    pulse_start();
    chk("R7 overflow on start while armed", 32'(ovf), 1);
    send_frame(9, 3, 1'b1);
    chk("R5 done after second frame", 32'(done), 1);
    chk("R7 overflow holds",          32'(ovf),  1);
    check_buffer("frame3 R5");

    // short frame: only window rows 3 and 4 arrive
    pulse_start();
    chk("R2 start clears overflow", 32'(ovf), 0);
    send_frame(5, 4, 1'b1);
    chk("R6 short flag set",         32'(short_f), 1);
    chk("R6 R9 done clear on short", 32'(done),    0);
    check_buffer("short R6");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule